// File: doc/BRIEF.md
# Load/Store AXI4-Lite Manager Port

This block sits between a processor core's load/store unit and a 32-bit AXI4-Lite interconnect. The core raises a one-cycle request carrying an address, an access size (byte, halfword or word), a store/load flag, an unsigned-load flag and store data. The port turns it into a single-beat transaction on the AXI4-Lite channels and later answers the core with a one-cycle completion pulse, the load result and a fault flag.

For stores the port copies the byte or halfword onto every lane of its width and asserts only the strobe bits of the addressed bytes. For loads it moves the addressed byte or halfword down to bit 0 and then sign- or zero-extends it. At most one transaction is in flight. Requests that arrive while one is pending are dropped. A request whose address is not a multiple of its size never reaches the bus and is answered at once with a misalignment flag. Both response-channel ready outputs are tied high, the protection outputs are tied to zero, and any non-zero response code is reported as an access fault.

Top module: `lsu_axil_port`

## Requirements
- R1: While reset is asserted and after it is released, `awvalid`, `wvalid`, `arvalid`, `done`, `fault`, `misalign` and `busy` are low until a request is accepted.
- R2: An aligned store request raises `awvalid` and `wvalid` together on the cycle after `req_valid`. Each stays high, with stable address, data and strobes, until its own ready is sampled high, independently of the other. `awaddr` equals `req_addr`.
- R3: Size codes are 0 for a byte, 1 for a halfword and 2 for a word. Bits [1:0] of the address select the lanes. A byte store puts `req_wdata[7:0]` on all four lanes and asserts strobe bit `addr[1:0]`. A halfword store puts `req_wdata[15:0]` on both halves and asserts `4'b0011` (addr[1]=0) or `4'b1100` (addr[1]=1). A word store asserts `4'b1111`.
- R4: A store completes when `bvalid` is sampled high. `done` pulses on the next cycle, `fault` equals `bresp != 0` in that cycle, and `busy` falls.
- R5: An aligned load request raises `arvalid` on the cycle after `req_valid` with `araddr = req_addr`, held stable until `arready` is sampled high.
- R6: A load completes when `rvalid` is sampled high. On the next cycle `done` pulses and `rsp_rdata` holds the addressed byte or halfword shifted to bit 0. It is zero-extended when `req_unsigned` was 1 and sign-extended when it was 0. A word load returns `rdata` unchanged.
- R7: A load whose `rresp` is non-zero sets `fault` with `done`, and `rsp_rdata` reads zero.
- R8: A halfword request with addr[0]=1, a word request with addr[1:0]!=0, or size code 3 gives `done` and `misalign` high on the next cycle, with `fault` low, and no valid is raised on any channel.
- R9: Only one transaction is in flight. A `req_valid` while `busy` is high has no effect on any channel and produces no extra `done`. Read and write valids are never high together.
- R10: `bready` and `rready` are always 1. `awprot` and `arprot` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | One-cycle request strobe from the core |
| req_store | input | 1 | 1 = store, 0 = load |
| req_unsigned | input | 1 | 1 = zero-extend load data, 0 = sign-extend |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| busy | output | 1 | A transaction is in flight |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Access fault, valid with done |
| misalign | output | 1 | Misaligned request, valid with done |
| rsp_rdata | output | 32 | Extended load result, valid with done |
| awaddr | output | 32 | Write address |
| awprot | output | 3 | Write protection, tied to zero |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| wdata | output | 32 | Write data on byte lanes |
| wstrb | output | 4 | Write byte strobes |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| bresp | input | 2 | Write response code |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready, tied high |
| araddr | output | 32 | Read address |
| arprot | output | 3 | Read protection, tied to zero |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| rdata | input | 32 | Read data |
| rresp | input | 2 | Read response code |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready, tied high |

## Verification
The assertions assume that the subordinate follows AXI4-Lite ordering: `bvalid` comes only after both write handshakes, `rvalid` only after the read address handshake, and no response arrives while the port is idle. The stability checks also assume that the core drives `req_valid` only as a single-cycle pulse. The bench behaves as such a subordinate. It raises the readies after chosen delays, returns a response only after those handshakes, and gives each request as a single-cycle pulse. Its one out-of-turn request is made while a load is pending, which is the case the port must ignore.

// File: rtl/lsu_axil_pkg.sv
package lsu_axil_pkg;

  localparam int SZ_W = 2;

  typedef enum logic [SZ_W-1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2
  } port_state_e;

  // low-address mask covering the bytes of one access of the given size
  function automatic int unsigned size_lo_mask(input logic [SZ_W-1:0] sz);
    return (32'd1 << sz) - 32'd1;
  endfunction

endpackage

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_axil_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [SZ_W-1:0]                    size,
  input  logic [$clog2(DATA_W/8)-1:0]        addr_lo,
  input  logic [DATA_W-1:0]                  data_in,
  output logic [DATA_W-1:0]                  lane_data,
  output logic [DATA_W/8-1:0]                lane_strb
);

  localparam int LANES  = DATA_W / 8;
  localparam int LIDX_W = $clog2(LANES);

  logic [LIDX_W-1:0] sz_mask;

  always_comb begin
    sz_mask = LIDX_W'(size_lo_mask(size));
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [LIDX_W-1:0] LANE_IDX = LIDX_W'(g);
    logic [LIDX_W-1:0] src_idx;

    always_comb begin
      src_idx               = LANE_IDX & sz_mask;
      lane_data[g*8 +: 8]   = data_in[src_idx*8 +: 8];
      lane_strb[g]          = (((LANE_IDX ^ addr_lo) & ~sz_mask) == '0);
    end
  end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_axil_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [SZ_W-1:0]              size,
  input  logic [$clog2(DATA_W/8)-1:0]  addr_lo,
  input  logic                         zero_ext,
  input  logic [DATA_W-1:0]            bus_data,
  output logic [DATA_W-1:0]            ext_data
);

  localparam int LIDX_W = $clog2(DATA_W/8);

  logic [DATA_W-1:0] shifted;
  logic              fill;

  always_comb begin
    shifted  = bus_data >> {addr_lo, 3'b000};
    fill     = 1'b0;
    ext_data = shifted;
    unique case (size)
      SZ_BYTE: begin
        fill     = ~zero_ext & shifted[7];
        ext_data = {{(DATA_W-8){fill}}, shifted[7:0]};
      end
      SZ_HALF: begin
        fill     = ~zero_ext & shifted[15];
        ext_data = {{(DATA_W-16){fill}}, shifted[15:0]};
      end
      default: ext_data = shifted;
    endcase
  end

  logic unused_w;
  assign unused_w = (LIDX_W == 0);

endmodule

// File: rtl/lsu_axil_ctrl.sv
module lsu_axil_ctrl
  import lsu_axil_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_store,
  input  logic req_misal,
  input  logic awready,
  input  logic wready,
  input  logic bvalid,
  input  logic bresp_err,
  input  logic arready,
  input  logic rvalid,
  input  logic rresp_err,
  output logic accept,
  output logic rd_capture,
  output logic awvalid,
  output logic wvalid,
  output logic arvalid,
  output logic done,
  output logic fault,
  output logic misalign,
  output logic busy
);

  port_state_e state_q, state_d;
  logic aw_q, aw_d, w_q, w_d, ar_q, ar_d;
  logic done_q, done_d, fault_q, fault_d, misal_q, misal_d;

  always_comb begin
    state_d    = state_q;
    aw_d       = aw_q;
    w_d        = w_q;
    ar_d       = ar_q;
    done_d     = 1'b0;
    fault_d    = 1'b0;
    misal_d    = 1'b0;
    accept     = 1'b0;
    rd_capture = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_misal) begin
            done_d  = 1'b1;
            misal_d = 1'b1;
          end else begin
            accept = 1'b1;
            if (req_store) begin
              state_d = ST_WRITE;
              aw_d    = 1'b1;
              w_d     = 1'b1;
            end else begin
              state_d = ST_READ;
              ar_d    = 1'b1;
            end
          end
        end
      end
      ST_WRITE: begin
        aw_d = aw_q & ~awready;
        w_d  = w_q & ~wready;
        if (bvalid) begin
          done_d  = 1'b1;
          fault_d = bresp_err;
          state_d = ST_IDLE;
          aw_d    = 1'b0;
          w_d     = 1'b0;
        end
      end
      ST_READ: begin
        ar_d = ar_q & ~arready;
        if (rvalid) begin
          rd_capture = 1'b1;
          done_d     = 1'b1;
          fault_d    = rresp_err;
          state_d    = ST_IDLE;
          ar_d       = 1'b0;
        end
      end
      default: begin
        state_d = ST_IDLE;
        aw_d    = 1'b0;
        w_d     = 1'b0;
        ar_d    = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      aw_q    <= 1'b0;
      w_q     <= 1'b0;
      ar_q    <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      misal_q <= 1'b0;
    end else begin
      state_q <= state_d;
      aw_q    <= aw_d;
      w_q     <= w_d;
      ar_q    <= ar_d;
      done_q  <= done_d;
      fault_q <= fault_d;
      misal_q <= misal_d;
    end
  end

  assign awvalid  = aw_q;
  assign wvalid   = w_q;
  assign arvalid  = ar_q;
  assign done     = done_q;
  assign fault    = fault_q;
  assign misalign = misal_q;
  assign busy     = (state_q != ST_IDLE);

endmodule

// File: rtl/lsu_axil_port.sv
module lsu_axil_port
  import lsu_axil_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int RESP_W = 2,
  parameter int PROT_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_store,
  input  logic                 req_unsigned,
  input  logic [1:0]           req_size,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 busy,
  output logic                 done,
  output logic                 fault,
  output logic                 misalign,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic [ADDR_W-1:0]    awaddr,
  output logic [PROT_W-1:0]    awprot,
  output logic                 awvalid,
  input  logic                 awready,
  output logic [DATA_W-1:0]    wdata,
  output logic [DATA_W/8-1:0]  wstrb,
  output logic                 wvalid,
  input  logic                 wready,
  input  logic [RESP_W-1:0]    bresp,
  input  logic                 bvalid,
  output logic                 bready,
  output logic [ADDR_W-1:0]    araddr,
  output logic [PROT_W-1:0]    arprot,
  output logic                 arvalid,
  input  logic                 arready,
  input  logic [DATA_W-1:0]    rdata,
  input  logic [RESP_W-1:0]    rresp,
  input  logic                 rvalid,
  output logic                 rready
);

  localparam int              LANES  = DATA_W / 8;
  localparam int              LIDX_W = $clog2(LANES);
  localparam logic [SZ_W-1:0] MAX_SZ = SZ_W'(LIDX_W);

  logic                 req_misal;
  logic [LIDX_W-1:0]    req_mask;
  logic                 accept, rd_capture;
  logic [ADDR_W-1:0]    addr_q;
  logic [SZ_W-1:0]      size_q;
  logic                 zext_q;
  logic [DATA_W-1:0]    sdata_q;
  logic [DATA_W-1:0]    load_ext;
  logic [DATA_W-1:0]    rsp_q, rsp_d;

  always_comb begin
    req_mask  = LIDX_W'(size_lo_mask(req_size));
    req_misal = (req_size > MAX_SZ) ||
                ((req_addr[LIDX_W-1:0] & req_mask) != '0);
  end

  lsu_axil_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_store  (req_store),
    .req_misal  (req_misal),
    .awready    (awready),
    .wready     (wready),
    .bvalid     (bvalid),
    .bresp_err  (|bresp),
    .arready    (arready),
    .rvalid     (rvalid),
    .rresp_err  (|rresp),
    .accept     (accept),
    .rd_capture (rd_capture),
    .awvalid    (awvalid),
    .wvalid     (wvalid),
    .arvalid    (arvalid),
    .done       (done),
    .fault      (fault),
    .misalign   (misalign),
    .busy       (busy)
  );

  // request capture, enabled by acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      size_q  <= '0;
      zext_q  <= 1'b0;
      sdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      size_q  <= req_size;
      zext_q  <= req_unsigned;
      sdata_q <= req_wdata;
    end
  end

  lsu_store_lanes #(.DATA_W(DATA_W)) u_store (
    .size      (size_q),
    .addr_lo   (addr_q[LIDX_W-1:0]),
    .data_in   (sdata_q),
    .lane_data (wdata),
    .lane_strb (wstrb)
  );

  lsu_load_extract #(.DATA_W(DATA_W)) u_load (
    .size     (size_q),
    .addr_lo  (addr_q[LIDX_W-1:0]),
    .zero_ext (zext_q),
    .bus_data (rdata),
    .ext_data (load_ext)
  );

  always_comb begin
    rsp_d = (|rresp) ? '0 : load_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q <= '0;
    end else if (rd_capture) begin
      rsp_q <= rsp_d;
    end
  end

  assign rsp_rdata = rsp_q;
  assign awaddr    = addr_q;
  assign araddr    = addr_q;
  assign awprot    = '0;
  assign arprot    = '0;
  assign bready    = 1'b1;
  assign rready    = 1'b1;

endmodule

// File: rtl/lsu_axil_port_chk.sv
module lsu_axil_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        done,
  input logic        fault,
  input logic        misalign,
  input logic [31:0] awaddr,
  input logic        awvalid,
  input logic        awready,
  input logic [31:0] wdata,
  input logic [3:0]  wstrb,
  input logic        wvalid,
  input logic        wready,
  input logic [31:0] araddr,
  input logic        arvalid,
  input logic        arready
);

  assert_aw_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && !awready) |=> (awvalid && $stable(awaddr)));

  assert_w_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid && !wready) |=> (wvalid && $stable(wdata) && $stable(wstrb)));

  assert_aw_w_together_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(awvalid) |-> $rose(wvalid));

  assert_strb_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid |-> (wstrb != 4'b0000));

  assert_fault_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done);

  assert_ar_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (arvalid && !arready) |=> (arvalid && $stable(araddr)));

  assert_misalign_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (done && !fault && !arvalid && !awvalid && !wvalid));

  assert_single_flight_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(arvalid && (awvalid || wvalid)));

  assert_ar_from_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arvalid) |-> $past(req_valid));

endmodule

bind lsu_axil_port lsu_axil_port_chk u_chk (.*);

// File: tb/lsu_axil_port_bench.sv
module lsu_axil_port_bench;

  typedef struct packed {
    logic        is_store;
    logic        uns;
    logic [1:0]  size;
    logic [31:0] addr;
    logic [31:0] data;
    logic [31:0] expd;
    logic [3:0]  strb;
    logic [3:0]  d0;
    logic [3:0]  d1;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 2'd0, 32'h1000_0003, 32'h0000_00A5, 32'hA5A5_A5A5, 4'b1000, 4'd0, 4'd0},
    '{1'b1, 1'b0, 2'd0, 32'h1000_0001, 32'h1234_5678, 32'h7878_7878, 4'b0010, 4'd2, 4'd0},
    '{1'b1, 1'b0, 2'd1, 32'h1000_0002, 32'h0000_BEEF, 32'hBEEF_BEEF, 4'b1100, 4'd0, 4'd3},
    '{1'b1, 1'b0, 2'd1, 32'h1000_0000, 32'hFFFF_1234, 32'h1234_1234, 4'b0011, 4'd1, 4'd1},
    '{1'b1, 1'b0, 2'd2, 32'h1000_0004, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'b1111, 4'd3, 4'd1},
    '{1'b0, 1'b0, 2'd0, 32'h2000_0002, 32'h1182_3344, 32'hFFFF_FF82, 4'b0000, 4'd0, 4'd0},
    '{1'b0, 1'b1, 2'd0, 32'h2000_0002, 32'h1182_3344, 32'h0000_0082, 4'b0000, 4'd2, 4'd1},
    '{1'b0, 1'b0, 2'd1, 32'h2000_0002, 32'h8001_7FFF, 32'hFFFF_8001, 4'b0000, 4'd1, 4'd0},
    '{1'b0, 1'b0, 2'd1, 32'h2000_0000, 32'h8001_7FFF, 32'h0000_7FFF, 4'b0000, 4'd0, 4'd2},
    '{1'b0, 1'b1, 2'd1, 32'h2000_0002, 32'h8001_7FFF, 32'h0000_8001, 4'b0000, 4'd3, 4'd0},
    '{1'b0, 1'b0, 2'd2, 32'h2000_0008, 32'hCAFE_F00D, 32'hCAFE_F00D, 4'b0000, 4'd1, 4'd1},
    '{1'b0, 1'b0, 2'd0, 32'h2000_0000, 32'h0000_007F, 32'h0000_007F, 4'b0000, 4'd0, 4'd0}
  };

  logic        clk, rst_n;
  logic        req_valid, req_store, req_unsigned;
  logic [1:0]  req_size;
  logic [31:0] req_addr, req_wdata;
  logic        busy, done, fault, misalign;
  logic [31:0] rsp_rdata, awaddr, wdata, araddr, rdata;
  logic [2:0]  awprot, arprot;
  logic        awvalid, awready, wvalid, wready, bvalid, bready;
  logic        arvalid, arready, rvalid, rready;
  logic [3:0]  wstrb;
  logic [1:0]  bresp, rresp;

  int n_cmp = 0;
  int n_bad = 0;

  lsu_axil_port u_lsu_axil_port (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_store(req_store), .req_unsigned(req_unsigned),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .fault(fault), .misalign(misalign), .rsp_rdata(rsp_rdata),
    .awaddr(awaddr), .awprot(awprot), .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .araddr(araddr), .arprot(arprot), .arvalid(arvalid), .arready(arready),
    .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic st, input logic uns, input logic [1:0] sz,
                       input logic [31:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_store = st; req_unsigned = uns;
    req_size = sz; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_store(input vec_t v, input logic [1:0] br);
    int last;
    last = (v.d0 > v.d1) ? int'(v.d0) : int'(v.d1);
    issue(1'b1, 1'b0, v.size, v.addr, v.data);
    chk(awaddr == v.addr, "R2 awaddr", awaddr, v.addr);
    chk(wdata == v.expd, "R3 wdata lanes", wdata, v.expd);
    chk(wstrb == v.strb, "R3 wstrb", {28'd0, wstrb}, {28'd0, v.strb});
    for (int c = 0; c <= last; c++) begin
      chk(awvalid == (c <= int'(v.d0)), "R2 awvalid hold", {31'd0, awvalid}, {31'd0, c <= int'(v.d0)});
      chk(wvalid == (c <= int'(v.d1)), "R2 wvalid hold", {31'd0, wvalid}, {31'd0, c <= int'(v.d1)});
      awready = (c == int'(v.d0));
      wready  = (c == int'(v.d1));
      @(posedge clk); @(negedge clk);
    end
    awready = 1'b0; wready = 1'b0;
    chk(!awvalid && !wvalid, "R2 valids drop", {30'd0, awvalid, wvalid}, 32'd0);
    chk(!done, "R4 no early done", {31'd0, done}, 32'd0);
    bvalid = 1'b1; bresp = br;
    @(posedge clk); @(negedge clk);
    bvalid = 1'b0; bresp = 2'd0;
    chk(done, "R4 store done", {31'd0, done}, 32'd1);
    chk(fault == (br != 2'd0), "R4 store fault", {31'd0, fault}, {31'd0, br != 2'd0});
    chk(!busy, "R4 idle after store", {31'd0, busy}, 32'd0);
  endtask

  task automatic run_load(input vec_t v, input logic [1:0] rr);
    logic [31:0] exp;
    issue(1'b0, v.uns, v.size, v.addr, 32'h0);
    chk(araddr == v.addr, "R5 araddr", araddr, v.addr);
    for (int c = 0; c <= int'(v.d0); c++) begin
      chk(arvalid == 1'b1, "R5 arvalid hold", {31'd0, arvalid}, 32'd1);
      chk(!awvalid && !wvalid, "R9 no write during load", {30'd0, awvalid, wvalid}, 32'd0);
      arready = (c == int'(v.d0));
      @(posedge clk); @(negedge clk);
    end
    arready = 1'b0;
    chk(!arvalid, "R5 arvalid drop", {31'd0, arvalid}, 32'd0);
    for (int c = 0; c < int'(v.d1); c++) begin
      @(posedge clk); @(negedge clk);
    end
    rvalid = 1'b1; rdata = v.data; rresp = rr;
    @(posedge clk); @(negedge clk);
    rvalid = 1'b0; rdata = 32'h5555_5555; rresp = 2'd0;
    exp = (rr != 2'd0) ? 32'h0 : v.expd;
    chk(done, "R6 load done", {31'd0, done}, 32'd1);
    chk(rsp_rdata == exp, (rr != 2'd0) ? "R7 faulted load data" : "R6 load extract", rsp_rdata, exp);
    chk(fault == (rr != 2'd0), "R7 load fault", {31'd0, fault}, {31'd0, rr != 2'd0});
  endtask

  task automatic run_misal(input logic [1:0] sz, input logic [31:0] a, input string tag);
    issue(1'b0, 1'b0, sz, a, 32'h0);
    chk(done && misalign && !fault, {tag, " R8 done+misalign"}, {29'd0, done, misalign, fault}, 32'd6);
    chk(!arvalid && !awvalid && !wvalid, {tag, " R8 no bus"}, {29'd0, arvalid, awvalid, wvalid}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk(!done && !misalign && !arvalid, {tag, " R8 one pulse"}, {30'd0, done, arvalid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R9: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    vec_t v;
    rst_n = 1'b0; req_valid = 1'b0; req_store = 1'b0; req_unsigned = 1'b0;
    req_size = 2'd0; req_addr = 32'h0; req_wdata = 32'h0;
    awready = 1'b0; wready = 1'b0; bvalid = 1'b0; bresp = 2'd0;
    arready = 1'b0; rvalid = 1'b0; rdata = 32'h0; rresp = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!awvalid && !wvalid && !arvalid && !done && !busy, "R1 in reset",
        {27'd0, awvalid, wvalid, arvalid, done, busy}, 32'd0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(!awvalid && !wvalid && !arvalid && !done && !fault && !misalign && !busy, "R1 after reset",
        {25'd0, awvalid, wvalid, arvalid, done, fault, misalign, busy}, 32'd0);
    chk(bready && rready, "R10 readies high", {30'd0, bready, rready}, 32'd3);
    chk(awprot == 3'd0 && arprot == 3'd0, "R10 prot zero", {26'd0, awprot, arprot}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_store) run_store(VECS[i], 2'd0);
      else                  run_load(VECS[i], 2'd0);
    end

    // faults
    v = VECS[4];
    run_store(v, 2'd2);
    v = VECS[5];
    run_load(v, 2'd3);
    chk(bready && rready && awprot == 3'd0, "R10 after faults", {29'd0, bready, rready, awprot == 3'd0}, 32'd7);

    // misaligned and reserved size
    run_misal(2'd1, 32'h3000_0003, "half@3");
    run_misal(2'd2, 32'h3000_0002, "word@2");
    run_misal(2'd3, 32'h3000_0000, "size3");

    // request while busy is ignored
    issue(1'b0, 1'b0, 2'd2, 32'h4000_0010, 32'h0);
    chk(busy && arvalid, "R9 load pending", {30'd0, busy, arvalid}, 32'd3);
    issue(1'b1, 1'b0, 2'd2, 32'h4000_0020, 32'hFFFF_FFFF);
    chk(!awvalid && !wvalid && arvalid, "R9 store ignored", {29'd0, awvalid, wvalid, arvalid}, 32'd1);
    chk(araddr == 32'h4000_0010, "R9 araddr kept", araddr, 32'h4000_0010);
    arready = 1'b1;
    @(posedge clk); @(negedge clk);
    arready = 1'b0;
    rvalid = 1'b1; rdata = 32'h0BAD_F00D; rresp = 2'd0;
    @(posedge clk); @(negedge clk);
    rvalid = 1'b0;
    chk(done && rsp_rdata == 32'h0BAD_F00D, "R9 first load completes", rsp_rdata, 32'h0BAD_F00D);
    @(posedge clk); @(negedge clk);
    chk(!done && !busy && !awvalid && !wvalid, "R9 no extra done",
        {28'd0, done, busy, awvalid, wvalid}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule